// File: doc/BRIEF.md
# Configurable Programmable I/O Cell

This block models one I/O cell of a programmable-logic fabric. Static configuration inputs decide how it behaves. A signal from internal logic can reach the pad on either of two paths: directly, or through a cell register. The pad's output enable can be taken straight from its control source or through a second register. The same data register can instead capture the pad level and hand it back to internal routing. Pad electrical behaviour is not modelled. The only exceptions are a pass-through slew select and a simple keeper that holds the last driven level.

The cell register runs on one of several global clocks, and the active edge is chosen per cell. Three cell controls are output enable, asynchronous register reset and register clock enable. Each of them picks its source from one shared pool. The pool holds the global active-high control lines, followed by the locally generated control lines. Select codes that point past the end of the pool give a constant inactive value.

Top module: `pio_cell`

## Requirements
- R1: The cell registers update on the rising edge of `gclk_i[cfg_clk_sel_i]` when `cfg_clk_inv_i` is 0, and on its falling edge when it is 1.
- R2: Each control select indexes the pool. Codes 0 to 3 pick `gctl_i[0..3]` and codes 4 to 9 pick `lctl_i[0..5]`. Codes 10 to 15 pick a constant: 1 for output enable and clock enable, 0 for reset.
- R3: While the selected reset line is 1, the data register, the output-enable register and the keeper read 0 at once, whatever the clock is doing.
- R4: When the selected clock-enable line is 0 at an active edge, the data register and the output-enable register keep their values.
- R5: At an enabled active edge, the data register loads `core_out_i` when `cfg_cap_pad_i` is 0 and `pad_in_i` when it is 1.
- R6: The value driven to the pad is the data register when `cfg_out_reg_i` is 1, and `core_out_i` when it is 0.
- R7: `pad_oe_o` is the selected enable line when `cfg_oe_reg_i` is 0. When it is 1, `pad_oe_o` is the value that line had at the last enabled active edge.
- R8: `core_in_o` is `pad_in_i` when `cfg_in_reg_i` is 0, and the data register when it is 1.
- R9: At every active edge where `pad_oe_o` is 1, the keeper loads the driven value. With `pad_oe_o` at 0, `pad_keep_o` equals `cfg_hold_i` and `pad_o` shows the keeper if `cfg_hold_i` is 1, or 0 if it is not. With `pad_oe_o` at 1, `pad_keep_o` is 0 and `pad_o` is the driven value.
- R10: `slew_fast_o` is the inverse of `cfg_slew_slow_i`, so the all-zero configuration selects the fast edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | 4 | Global clocks |
| gctl_i | input | 4 | Global active-high control lines, pool codes 0..3 |
| lctl_i | input | 6 | Local control lines, pool codes 4..9 |
| core_out_i | input | 1 | Output data from internal logic |
| pad_in_i | input | 1 | Level sensed at the pad |
| cfg_clk_sel_i | input | 2 | Global clock select |
| cfg_clk_inv_i | input | 1 | 1 = clock on the falling edge |
| cfg_oe_sel_i | input | 4 | Output-enable source code |
| cfg_rst_sel_i | input | 4 | Reset source code |
| cfg_ce_sel_i | input | 4 | Clock-enable source code |
| cfg_oe_reg_i | input | 1 | 1 = registered output enable |
| cfg_out_reg_i | input | 1 | 1 = drive the pad from the register |
| cfg_cap_pad_i | input | 1 | 1 = register captures the pad |
| cfg_in_reg_i | input | 1 | 1 = routing sees the register |
| cfg_hold_i | input | 1 | Keeper enable |
| cfg_slew_slow_i | input | 1 | 1 = slow edge rate |
| pad_o | output | 1 | Pad level as driven or held |
| pad_oe_o | output | 1 | Pad driver enable |
| pad_keep_o | output | 1 | Keeper is holding the pad |
| core_in_o | output | 1 | Input data to internal routing |
| slew_fast_o | output | 1 | Fast edge-rate select |

## Verification
The clocked assertions assume that the effective cell clock makes no edge of its own except through the selected global clock. The stimulus therefore changes the clock select and the edge polarity only while the selected reset is held, because a polarity flip would otherwise create an edge. The assertions also assume that every reset pulse spans at least one active edge and that inputs never move at a clock edge. The stimulus meets this by holding each reset for several clock periods and by changing inputs one nanosecond after each half-period boundary.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned GCTL_LINES = 4;
   localparam int unsigned LCTL_LINES = 6;
   localparam int unsigned GCLK_LINES = 4;
   localparam bit ENABLE_IDLE = 1'b1;
   localparam bit RESET_IDLE  = 1'b0;
endpackage

// File: rtl/pio_ctl_pick.sv
module pio_ctl_pick #(
   parameter int unsigned LINES = 10,
   parameter int unsigned SEL_W = 4,
   parameter bit          IDLE  = 1'b0
) (
   input  logic [LINES-1:0] lines_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             pick_o
);
   localparam int unsigned CODES = 2 ** SEL_W;

   if (LINES >= CODES) begin : g_no_idle_code
      $error("pio_ctl_pick: select field leaves no idle code");
   end

   logic [CODES-1:0] code_map;

   for (genvar i = 0; i < CODES; i++) begin : g_code
      if (i < LINES) begin : g_line
         assign code_map[i] = lines_i[i];
      end else begin : g_idle
         assign code_map[i] = IDLE;
      end
   end

   assign pick_o = code_map[sel_i];
endmodule

// File: rtl/pio_clk_pick.sv
module pio_clk_pick #(
   parameter int unsigned N_CLK = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic [N_CLK-1:0] gclk_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             inv_i,
   output logic             clk_o
);
   if (N_CLK < 1) begin : g_no_clock
      $error("pio_clk_pick: at least one clock needed");
   end

   logic raw_clk;

   if (N_CLK == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign raw_clk    = gclk_i[0];
   end else begin : g_mux
      assign raw_clk = (32'(sel_i) < N_CLK) ? gclk_i[sel_i] : 1'b0;
   end

   assign clk_o = raw_clk ^ inv_i;
endmodule

// File: rtl/pio_store.sv
module pio_store (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ce_i,
   input  logic d_i,
   input  logic oe_d_i,
   input  logic drv_en_i,
   input  logic drv_val_i,
   output logic q_o,
   output logic oe_q_o,
   output logic keep_q_o
);
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         q_o    <= 1'b0;
         oe_q_o <= 1'b0;
      end else if (ce_i) begin
         q_o    <= d_i;
         oe_q_o <= oe_d_i;
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)         keep_q_o <= 1'b0;
      else if (drv_en_i) keep_q_o <= drv_val_i;
   end

   a_r3_reset_clears: assert property (@(posedge clk_i)
      rst_i |-> (q_o == 1'b0 && oe_q_o == 1'b0 && keep_q_o == 1'b0));

   a_r5_capture: assert property (@(posedge clk_i) disable iff (rst_i)
      ce_i |=> q_o == $past(d_i));

   a_r7_oe_capture: assert property (@(posedge clk_i) disable iff (rst_i)
      ce_i |=> oe_q_o == $past(oe_d_i));

   a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
      !ce_i |=> ($stable(q_o) && $stable(oe_q_o)));

   a_r9_keeper_loads: assert property (@(posedge clk_i) disable iff (rst_i)
      drv_en_i |=> keep_q_o == $past(drv_val_i));
endmodule

// File: rtl/pio_cell.sv
module pio_cell
   import pio_pkg::*;
#(
   parameter  int unsigned N_GCTL = GCTL_LINES,
   parameter  int unsigned N_LCTL = LCTL_LINES,
   parameter  int unsigned N_GCLK = GCLK_LINES,
   localparam int unsigned N_CTL  = N_GCTL + N_LCTL,
   localparam int unsigned SEL_W  = $clog2(N_CTL + 1),
   localparam int unsigned CSEL_W = (N_GCLK > 1) ? $clog2(N_GCLK) : 1
) (
   input  logic [N_GCLK-1:0] gclk_i,
   input  logic [N_GCTL-1:0] gctl_i,
   input  logic [N_LCTL-1:0] lctl_i,
   input  logic              core_out_i,
   input  logic              pad_in_i,
   input  logic [CSEL_W-1:0] cfg_clk_sel_i,
   input  logic              cfg_clk_inv_i,
   input  logic [SEL_W-1:0]  cfg_oe_sel_i,
   input  logic [SEL_W-1:0]  cfg_rst_sel_i,
   input  logic [SEL_W-1:0]  cfg_ce_sel_i,
   input  logic              cfg_oe_reg_i,
   input  logic              cfg_out_reg_i,
   input  logic              cfg_cap_pad_i,
   input  logic              cfg_in_reg_i,
   input  logic              cfg_hold_i,
   input  logic              cfg_slew_slow_i,
   output logic              pad_o,
   output logic              pad_oe_o,
   output logic              pad_keep_o,
   output logic              core_in_o,
   output logic              slew_fast_o
);
   if (N_GCTL < 1 || N_LCTL < 1) begin : g_bad_pool
      $error("pio_cell: control pool needs global and local lines");
   end

   logic [N_CTL-1:0] ctl_pool;
   logic cell_clk, oe_line, rst_line, ce_line;
   logic reg_d, reg_q, oe_q, keep_q, drive_val;

   // pool order is behaviour: global lines take the low codes
   assign ctl_pool = {lctl_i, gctl_i};

   pio_clk_pick #(.N_CLK(N_GCLK), .SEL_W(CSEL_W)) u_clk (
      .gclk_i(gclk_i), .sel_i(cfg_clk_sel_i), .inv_i(cfg_clk_inv_i), .clk_o(cell_clk));

   pio_ctl_pick #(.LINES(N_CTL), .SEL_W(SEL_W), .IDLE(ENABLE_IDLE)) u_oe_pick (
      .lines_i(ctl_pool), .sel_i(cfg_oe_sel_i), .pick_o(oe_line));

   pio_ctl_pick #(.LINES(N_CTL), .SEL_W(SEL_W), .IDLE(RESET_IDLE)) u_rst_pick (
      .lines_i(ctl_pool), .sel_i(cfg_rst_sel_i), .pick_o(rst_line));

   pio_ctl_pick #(.LINES(N_CTL), .SEL_W(SEL_W), .IDLE(ENABLE_IDLE)) u_ce_pick (
      .lines_i(ctl_pool), .sel_i(cfg_ce_sel_i), .pick_o(ce_line));

   assign reg_d     = cfg_cap_pad_i ? pad_in_i : core_out_i;
   assign drive_val = cfg_out_reg_i ? reg_q : core_out_i;
   assign pad_oe_o  = cfg_oe_reg_i ? oe_q : oe_line;

   pio_store u_store (
      .clk_i(cell_clk), .rst_i(rst_line), .ce_i(ce_line),
      .d_i(reg_d), .oe_d_i(oe_line),
      .drv_en_i(pad_oe_o), .drv_val_i(drive_val),
      .q_o(reg_q), .oe_q_o(oe_q), .keep_q_o(keep_q));

   always_comb begin
      if (pad_oe_o)        pad_o = drive_val;
      else if (cfg_hold_i) pad_o = keep_q;
      else                 pad_o = 1'b0;
   end

   assign pad_keep_o  = cfg_hold_i & ~pad_oe_o;
   assign core_in_o   = cfg_in_reg_i ? reg_q : pad_in_i;
   assign slew_fast_o = ~cfg_slew_slow_i;

   a_r2_idle_enable: assert property (@(posedge cell_clk) disable iff (rst_line)
      (32'(cfg_oe_sel_i) >= N_CTL && !cfg_oe_reg_i) |-> pad_oe_o);

   a_r6_registered_drive: assert property (@(posedge cell_clk) disable iff (rst_line)
      (ce_line && cfg_out_reg_i && !cfg_cap_pad_i) |=>
      (!pad_oe_o || !$stable(cfg_out_reg_i) || pad_o == $past(core_out_i)));

   a_r9_no_keep_while_driven: assert property (@(posedge cell_clk) disable iff (rst_line)
      pad_oe_o |-> !pad_keep_o);
endmodule

// File: tb/sim_pio_cell.sv
module sim_pio_cell;
   logic [3:0] gclk, gctl;
   logic [5:0] lctl;
   logic       core_out, pad_in;
   logic [1:0] clk_sel;
   logic       clk_inv, oe_reg, out_reg, cap_pad, in_reg, hold, slew_slow;
   logic [3:0] oe_sel, rst_sel, ce_sel;
   logic       pad, pad_oe, pad_keep, core_in, slew_fast;

   int checks = 0, errors = 0, ph = 0;
   string tag = "R3";
   logic [31:0] lfsr = 32'h1bad_c0de;
   logic m_q = 0, m_oe = 0, m_keep = 0;

   pio_cell u0 (
      .gclk_i(gclk), .gctl_i(gctl), .lctl_i(lctl), .core_out_i(core_out), .pad_in_i(pad_in),
      .cfg_clk_sel_i(clk_sel), .cfg_clk_inv_i(clk_inv), .cfg_oe_sel_i(oe_sel),
      .cfg_rst_sel_i(rst_sel), .cfg_ce_sel_i(ce_sel), .cfg_oe_reg_i(oe_reg),
      .cfg_out_reg_i(out_reg), .cfg_cap_pad_i(cap_pad), .cfg_in_reg_i(in_reg),
      .cfg_hold_i(hold), .cfg_slew_slow_i(slew_slow),
      .pad_o(pad), .pad_oe_o(pad_oe), .pad_keep_o(pad_keep), .core_in_o(core_in),
      .slew_fast_o(slew_fast));

   function automatic logic rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr[7];
   endfunction

   function automatic logic pick(input logic [3:0] code, input logic idle);
      logic [9:0] pool;
      pool = {lctl, gctl};
      return (code < 10) ? pool[code] : idle;
   endfunction

   function automatic logic eff(input int p);
      return logic'((p >> clk_sel) & 1) ^ clk_inv;
   endfunction

   task automatic check(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step();
      logic rst, ce, oel, drv_pre, oe_pre, rose, drv, oe, xp;
      #4;
      ph++;
      gclk = ph[3:0];
      #1;
      rst  = pick(rst_sel, 1'b0);
      ce   = pick(ce_sel, 1'b1);
      oel  = pick(oe_sel, 1'b1);
      drv_pre = out_reg ? m_q : core_out;
      oe_pre  = oe_reg ? m_oe : oel;
      rose = !eff(ph - 1) && eff(ph);
      if (rst) begin
         m_q = 0; m_oe = 0; m_keep = 0;
      end else if (rose) begin
         if (ce) begin
            m_q  = cap_pad ? pad_in : core_out;
            m_oe = oel;
         end
         if (oe_pre) m_keep = drv_pre;
      end
      drv = out_reg ? m_q : core_out;
      oe  = oe_reg ? m_oe : oel;
      xp  = oe ? drv : (hold ? m_keep : 1'b0);
      check("pad_oe_o", pad_oe, oe);
      check("pad_o", pad, xp);
      check("pad_keep_o", pad_keep, hold & ~oe);
      check("core_in_o", core_in, in_reg ? m_q : pad_in);
      check("slew_fast_o", slew_fast, ~slew_slow);
   endtask

   task automatic run(input int n, input bit rnd_lines);
      for (int i = 0; i < n; i++) begin
         core_out = rnd();
         pad_in   = rnd();
         if (rnd_lines) begin
            for (int b = 0; b < 6; b++) lctl[b] = rnd();
            for (int b = 0; b < 4; b++) gctl[b] = rnd();
         end
         step();
      end
   endtask

   // clock changes only under reset so no stray edge reaches the cell
   task automatic reclock(input logic [1:0] sel, input logic inv);
      gctl = 4'b0001; rst_sel = 4'd0;
      step(); step();
      clk_sel = sel; clk_inv = inv;
      for (int i = 0; i < 20; i++) step();
      rst_sel = 4'd15; gctl = 4'b0000;
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      gclk = 0; gctl = 0; lctl = 0; core_out = 0; pad_in = 0;
      clk_sel = 0; clk_inv = 0; oe_reg = 0; out_reg = 0; cap_pad = 0; in_reg = 0;
      hold = 0; slew_slow = 0; oe_sel = 4'd15; ce_sel = 4'd15; rst_sel = 4'd0;
      #1;
      tag = "R3"; gctl = 4'b0001;
      for (int i = 0; i < 16; i++) step();
      check("reset data reg via core_in", (in_reg = 1) ? core_in : 1'bx, 1'b0);
      in_reg = 0;
      rst_sel = 4'd15; gctl = 0;

      tag = "R1"; out_reg = 1; run(20, 0);
      reclock(2'd2, 1'b1); run(40, 0);
      reclock(2'd1, 1'b0); run(30, 0);
      reclock(2'd3, 1'b1); run(40, 0);
      reclock(2'd0, 1'b1); run(20, 0);
      reclock(2'd0, 1'b0);

      tag = "R2";
      for (int c = 0; c < 16; c++) begin
         oe_sel = 4'(c);
         run(4, 1);
      end

      tag = "R4"; oe_sel = 4'd15;
      ce_sel = 4'd6; run(30, 1);
      ce_sel = 4'd2; run(30, 1);
      ce_sel = 4'd15;

      tag = "R5"; cap_pad = 1; run(20, 0);
      tag = "R8"; in_reg = 1; run(20, 0); in_reg = 0; run(10, 0);
      cap_pad = 0;
      tag = "R6"; out_reg = 0; run(20, 0); out_reg = 1; run(10, 0);
      tag = "R7"; oe_reg = 1; oe_sel = 4'd7; run(30, 1);
      ce_sel = 4'd5; run(30, 1); ce_sel = 4'd15; oe_reg = 0;
      tag = "R9"; hold = 1; oe_sel = 4'd8; out_reg = 0; run(40, 1);
      out_reg = 1; run(20, 1); hold = 0; run(10, 1); oe_sel = 4'd15;
      tag = "R10"; slew_slow = 1; run(4, 0); slew_slow = 0; run(4, 0);

      tag = "R3"; rst_sel = 4'd9; lctl = 0;
      run(6, 0);
      lctl[5] = 1; run(4, 0);
      check("reset forces pad_oe stays enabled from idle code", pad_oe, 1'b1);
      lctl[5] = 0; run(10, 0);
      rst_sel = 4'd15;

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule